// File: doc/BRIEF.md
# Sync Output Pin Router

This block sits at the back end of a programmable raster timing generator. It takes the horizontal and vertical position counters, the raw blank and sync pulses that the timing core produces, and a set of window registers. From these it drives four registered output pins. The first pin carries blanking, either vertical only or composite. The second carries sync, either vertical only or composite. The third carries horizontal blank, a horizontal gate or a cursor window. The fourth carries horizontal sync, a vertical gate or a vertical interrupt.

A three-bit select field in the control word picks the signal on each pin, and four polarity bits set each pin to active high or active low. The gates and the cursor come from two counter windows. One is horizontal, on pixel counts. The other is vertical, on line counts. A third window on the line counter gives the vertical interrupt. A window is open when its counter is at or above the start value and below the end value.

Top module: `sync_pin_router`

## Requirements
- R1: While `rst` is high, all four pins are driven low.
- R2: Every pin is registered. The value on a pin after a rising clock edge depends only on the inputs sampled at that edge.
- R3: Blank pin: `ctrl_word[0]`=0 selects composite blank (`h_blank` OR `v_blank`), and 1 selects `v_blank`.
- R4: Sync pin: `ctrl_word[1]`=0 selects `c_sync`, and 1 selects `v_sync`.
- R5: Horizontal-blank pin: `ctrl_word[0]`=1 selects `h_blank`. Otherwise the pin carries the horizontal gate when `ctrl_word[2]`=0 and the cursor when `ctrl_word[2]`=1 (selects 000/010 give the gate, 100/110 give the cursor).
- R6: Horizontal-sync pin: `ctrl_word[1]`=1 selects `h_sync`. Otherwise the pin carries the vertical gate when `ctrl_word[2]`=0 and the vertical interrupt when `ctrl_word[2]`=1 (selects 000/001 give the gate, 100/101 give the interrupt).
- R7: Polarity bits `ctrl_word[5]`, `[6]`, `[7]` and `[8]` belong to the blank, sync, horizontal-blank and horizontal-sync pins in that order. A 1 passes the active signal as high, and a 0 inverts it so the active level is low.
- R8: A window is open when start <= counter < end. When start >= end the window is never open.
- R9: The horizontal gate uses only the horizontal window (`hcount` against `hwin_start`/`hwin_end`). The vertical gate uses only the vertical window (`vcount` against `vwin_start`/`vwin_end`). The cursor is open only when both windows are open.
- R10: The vertical interrupt is active when `vint_on` <= `vcount` < `vint_off`.
- R11: Control bits 3, 4, 9, 10 and 11 have no effect on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Asynchronous reset, active high |
| ctrl_word | input | 12 | Control word: select [2:0], polarity [8:5] |
| hcount | input | CW | Horizontal pixel counter |
| vcount | input | CW | Vertical line counter |
| hwin_start | input | CW | Horizontal window start count |
| hwin_end | input | CW | Horizontal window end count |
| vwin_start | input | CW | Vertical window start line |
| vwin_end | input | CW | Vertical window end line |
| vint_on | input | CW | Vertical interrupt first active line |
| vint_off | input | CW | Vertical interrupt first inactive line |
| h_blank | input | 1 | Raw horizontal blank, active high |
| h_sync | input | 1 | Raw horizontal sync, active high |
| v_blank | input | 1 | Raw vertical blank, active high |
| v_sync | input | 1 | Raw vertical sync, active high |
| c_sync | input | 1 | Raw composite sync with equalization/serration, active high |
| pin_vcblank | output | 1 | Vertical or composite blank pin |
| pin_vcsync | output | 1 | Vertical or composite sync pin |
| pin_hbl | output | 1 | Horizontal blank / horizontal gate / cursor pin |
| pin_hsv | output | 1 | Horizontal sync / vertical gate / vertical interrupt pin |

## Verification
The bench runs all eight select values with inputs that tell the pins apart, so a swapped table row shows up as the wrong source on some pin. It sets counters one below the start, at the start, one below the end and at the end of each window. An off-by-one in the comparison opens or closes a window one pixel or one line early. An empty window with start equal to end catches a design that opens a window on start alone. The bench also toggles each polarity bit separately, which catches a polarity bit wired to the wrong pin. It sets the unused control bits high, which catches a select decode that reads too many bits.

// File: rtl/sync_pin_router.sv
module sync_pin_router #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [11:0]   ctrl_word,
  input  logic [CW-1:0] hcount,
  input  logic [CW-1:0] vcount,
  input  logic [CW-1:0] hwin_start,
  input  logic [CW-1:0] hwin_end,
  input  logic [CW-1:0] vwin_start,
  input  logic [CW-1:0] vwin_end,
  input  logic [CW-1:0] vint_on,
  input  logic [CW-1:0] vint_off,
  input  logic          h_blank,
  input  logic          h_sync,
  input  logic          v_blank,
  input  logic          v_sync,
  input  logic          c_sync,
  output logic          pin_vcblank,
  output logic          pin_vcsync,
  output logic          pin_hbl,
  output logic          pin_hsv
);

  logic [2:0] sel;
  logic [3:0] pol;
  logic       h_open, v_open, vint_open;
  logic [3:0] active, pin_d, pin_q;

  assign sel = ctrl_word[2:0];
  assign pol = ctrl_word[8:5];

  assign h_open    = (hcount >= hwin_start) && (hcount < hwin_end);
  assign v_open    = (vcount >= vwin_start) && (vcount < vwin_end);
  assign vint_open = (vcount >= vint_on)    && (vcount < vint_off);

  assign active[0] = sel[0] ? v_blank : (h_blank | v_blank);
  assign active[1] = sel[1] ? v_sync  : c_sync;
  assign active[2] = sel[0] ? h_blank : (sel[2] ? (h_open & v_open) : h_open);
  assign active[3] = sel[1] ? h_sync  : (sel[2] ? vint_open : v_open);

  assign pin_d = active ^ ~pol;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) pin_q <= '0;
    else     pin_q <= pin_d;
  end

  assign pin_vcblank = pin_q[0];
  assign pin_vcsync  = pin_q[1];
  assign pin_hbl     = pin_q[2];
  assign pin_hsv     = pin_q[3];

endmodule

// File: rtl/sync_pin_router_chk.sv
module sync_pin_router_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic [11:0]   ctrl_word,
  input logic [CW-1:0] hcount,
  input logic [CW-1:0] vcount,
  input logic [CW-1:0] hwin_start,
  input logic [CW-1:0] vint_on,
  input logic          h_blank,
  input logic          h_sync,
  input logic          v_sync,
  input logic          pin_vcblank,
  input logic          pin_vcsync,
  input logic          pin_hbl,
  input logic          pin_hsv
);

  always_comb begin
    if (rst)
      a_r1_reset_low: assert (!pin_vcblank && !pin_vcsync && !pin_hbl && !pin_hsv);
  end

  a_r3_cblank_follows_hblank: assert property (@(posedge clk) disable iff (rst)
    ($past(ctrl_word[0]) == 1'b0 && $past(h_blank) && $past(ctrl_word[5])) |-> pin_vcblank);

  a_r4_vsync_low_active: assert property (@(posedge clk) disable iff (rst)
    ($past(ctrl_word[1]) && $past(v_sync) && !$past(ctrl_word[6])) |-> !pin_vcsync);

  a_r6_hsync_low_active: assert property (@(posedge clk) disable iff (rst)
    ($past(ctrl_word[1]) && !$past(h_sync) && !$past(ctrl_word[8])) |-> pin_hsv);

  a_r9_cursor_closed_left: assert property (@(posedge clk) disable iff (rst)
    ($past(ctrl_word[2:0]) == 3'b100 && ($past(hcount) < $past(hwin_start))
     && $past(ctrl_word[7])) |-> !pin_hbl);

  a_r10_vint_before_on: assert property (@(posedge clk) disable iff (rst)
    ($past(ctrl_word[2:0]) == 3'b101 && ($past(vcount) < $past(vint_on))
     && $past(ctrl_word[8])) |-> !pin_hsv);

endmodule

bind sync_pin_router sync_pin_router_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .hcount(hcount), .vcount(vcount),
  .hwin_start(hwin_start), .vint_on(vint_on), .h_blank(h_blank), .h_sync(h_sync),
  .v_sync(v_sync), .pin_vcblank(pin_vcblank), .pin_vcsync(pin_vcsync),
  .pin_hbl(pin_hbl), .pin_hsv(pin_hsv)
);

// File: tb/sync_pin_router_test.sv
module sync_pin_router_test;
  localparam int CW = 12;

  logic clk = 0;
  logic rst = 1;
  logic [11:0] ctrl_word = '0;
  logic [CW-1:0] hcount = '0, vcount = '0;
  logic [CW-1:0] hwin_start = '0, hwin_end = '0, vwin_start = '0, vwin_end = '0;
  logic [CW-1:0] vint_on = '0, vint_off = '0;
  logic h_blank = 0, h_sync = 0, v_blank = 0, v_sync = 0, c_sync = 0;
  logic pin_vcblank, pin_vcsync, pin_hbl, pin_hsv;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct { logic [3:0] exp; string tag; } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  sync_pin_router #(.CW(CW)) uut (.*);

  function automatic logic [3:0] model(input logic [2:0] s, input logic [3:0] p);
    logic hw, vw, cb, hg, vg, cur, vi;
    logic [3:0] a;
    hw  = (hcount >= hwin_start) && (hcount < hwin_end);
    vw  = (vcount >= vwin_start) && (vcount < vwin_end);
    vi  = (vcount >= vint_on) && (vcount < vint_off);
    cb  = h_blank | v_blank;
    hg  = hw; vg = vw; cur = hw & vw;
    case (s)
      3'b000: a = {vg,      hg,      c_sync, cb};
      3'b001: a = {vg,      h_blank, c_sync, v_blank};
      3'b010: a = {h_sync,  hg,      v_sync, cb};
      3'b011: a = {h_sync,  h_blank, v_sync, v_blank};
      3'b100: a = {vi,      cur,     c_sync, cb};
      3'b101: a = {vi,      h_blank, c_sync, v_blank};
      3'b110: a = {h_sync,  cur,     v_sync, cb};
      default: a = {h_sync, h_blank, v_sync, v_blank};
    endcase
    for (int i = 0; i < 4; i++) if (!p[i]) a[i] = ~a[i];
    return a;
  endfunction

  task automatic apply(input string tag, input logic [2:0] s, input logic [3:0] p,
                       input logic [4:0] spare, input logic [CW-1:0] hc,
                       input logic [CW-1:0] vc, input logic [4:0] raw);
    item_t it;
    @(negedge clk);
    ctrl_word = {spare[4:2], p, spare[1:0], s};
    hcount = hc; vcount = vc;
    {c_sync, v_sync, v_blank, h_sync, h_blank} = raw;
    it.exp = model(s, p);
    it.tag = tag;
    sb.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    logic [3:0] got;
    forever begin
      @(posedge clk); #2;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        got = {pin_hsv, pin_hbl, pin_vcsync, pin_vcblank};
        total++;
        if (got !== it.exp) begin
          bad++;
          $display("FAIL %s: pins got=%b expected=%b", it.tag, got, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    #(20 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    total++;
    if ({pin_hsv, pin_hbl, pin_vcsync, pin_vcblank} !== 4'b0000) begin
      bad++;
      $display("FAIL R1: got=%b expected=0000", {pin_hsv, pin_hbl, pin_vcsync, pin_vcblank});
    end
    hwin_start = 12'd100; hwin_end = 12'd200;
    vwin_start = 12'd20;  vwin_end = 12'd30;
    vint_on = 12'd5;      vint_off = 12'd8;
    @(negedge clk); rst = 0;

    // R3 R4 R5 R6: every select with each raw pulse alone and windows mixed
    for (int s = 0; s < 8; s++) begin
      for (int r = 0; r < 5; r++)
        apply("R3/R4/R5/R6 select", 3'(s), 4'hF, 5'd0, 12'd150, 12'd25, 5'(1 << r));
      apply("R5/R6/R9 windows open", 3'(s), 4'hF, 5'd0, 12'd150, 12'd25, 5'd0);
      apply("R9 h only", 3'(s), 4'hF, 5'd0, 12'd150, 12'd40, 5'd0);
      apply("R9 v only", 3'(s), 4'hF, 5'd0, 12'd50, 12'd22, 5'd0);
      apply("R10 vint", 3'(s), 4'hF, 5'd0, 12'd50, 12'd6, 5'd0);
    end

    // R7: each polarity bit alone
    for (int p = 0; p < 16; p++) begin
      apply("R7 polarity", 3'b000, 4'(p), 5'd0, 12'd150, 12'd25, 5'b10011);
      apply("R7 polarity", 3'b011, 4'(p), 5'd0, 12'd10, 12'd2, 5'b01100);
    end

    // R8 boundaries on the horizontal and vertical windows
    apply("R8 h start-1", 3'b000, 4'hF, 5'd0, 12'd99,  12'd25, 5'd0);
    apply("R8 h start",   3'b000, 4'hF, 5'd0, 12'd100, 12'd25, 5'd0);
    apply("R8 h end-1",   3'b000, 4'hF, 5'd0, 12'd199, 12'd25, 5'd0);
    apply("R8 h end",     3'b000, 4'hF, 5'd0, 12'd200, 12'd25, 5'd0);
    apply("R8 v start-1", 3'b000, 4'hF, 5'd0, 12'd150, 12'd19, 5'd0);
    apply("R8 v start",   3'b000, 4'hF, 5'd0, 12'd150, 12'd20, 5'd0);
    apply("R8 v end-1",   3'b100, 4'hF, 5'd0, 12'd150, 12'd29, 5'd0);
    apply("R8 v end",     3'b100, 4'hF, 5'd0, 12'd150, 12'd30, 5'd0);

    // R10 boundaries
    apply("R10 on-1",  3'b100, 4'hF, 5'd0, 12'd0, 12'd4, 5'd0);
    apply("R10 on",    3'b100, 4'hF, 5'd0, 12'd0, 12'd5, 5'd0);
    apply("R10 off-1", 3'b101, 4'hF, 5'd0, 12'd0, 12'd7, 5'd0);
    apply("R10 off",   3'b101, 4'hF, 5'd0, 12'd0, 12'd8, 5'd0);

    // R8 empty window: start equal to end
    @(negedge clk); hwin_end = 12'd100;
    apply("R8 empty at start", 3'b000, 4'hF, 5'd0, 12'd100, 12'd25, 5'd0);
    apply("R8 empty cursor",   3'b110, 4'hF, 5'd0, 12'd100, 12'd25, 5'd0);
    @(negedge clk); hwin_end = 12'd200;

    // R11: spare control bits set
    for (int s = 0; s < 8; s++)
      apply("R11 spare bits", 3'(s), 4'b1010, 5'b11111, 12'd150, 12'd6, 5'b10101);

    // R2: one-cycle latency across a fast toggle
    apply("R2 latency a", 3'b011, 4'hF, 5'd0, 12'd0, 12'd0, 5'b11111);
    apply("R2 latency b", 3'b011, 4'hF, 5'd0, 12'd0, 12'd0, 5'b00000);
    apply("R2 latency c", 3'b011, 4'hF, 5'd0, 12'd0, 12'd0, 5'b11111);

    wait (sb.size() == 0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule